// File: doc/BRIEF.md
# Paired-Channel Memory Block Copier

This block copies a run of bytes from one place in memory to another over an 8-bit bus. Two channels work as a pair. The source channel holds the address that is read, and the destination channel holds the address that is written. A byte is moved by a read cycle that captures the bus data in a holding register, followed by a write cycle that drives that register back out. The target can stretch either cycle by holding its ready line low. Both channels share one page register, so both addresses stay inside one 64 KiB segment. Each 16-bit offset wraps around without carrying into the page.

Software sets up the block through a small byte-wide register file. It loads the two offsets, the page, a count equal to the length minus one, a command byte and a mask byte. A request write then starts the copy, and the copy needs no hardware request pin. When the final byte has been written, the block drops its busy output, pulses its terminal-count output and leaves a terminal-count flag readable in the status register. An optional extended-write mode raises the write strobe one state early. The strobe then overlaps a slow target's wait-state reply instead of appearing only in the final state.

Top module: `m2m_dma`

## Requirements
- R1: After reset, busy, tc_out, bus_rd and bus_wr are low and the status register (offset 9) reads 0.
- R2: A register write to offset 9 with bit 0 set starts a copy only when command bit 1 (copy mode) is set and mask register (offset 8) bits 1:0 are both 1; otherwise the write has no effect and busy stays low.
- R3: Each byte is read from address {page, source offset} with bus_rd high and then written unchanged to {page, destination offset} on bus_dout, so the destination receives exactly the source bytes in order.
- R4: The read and write cycles each take four states. A low bus_ready in the third state or in a wait state adds a wait state before the fourth state, so a copy of N bytes with ready held high keeps busy high for exactly 8·N cycles.
- R5: With command bit 0 clear, bus_wr is high for only one cycle per byte. With command bit 0 set (extended write), bus_wr rises one state earlier and stays high through all wait states, for at least two cycles per byte.
- R6: After every byte, the source and destination offsets each increase by one. They wrap from 16'hFFFF to 16'h0000, and the page (offset 6) does not change.
- R7: The count register (offsets 4 low, 5 high) is loaded with length−1 and decreases once per byte. After the byte written at count 0, tc_out is high for exactly one cycle, the status register reads 8'h02 (bit 1 terminal count, bit 0 request, bit 2 busy) and the count reads 16'hFFFF.
- R8: busy goes high in the cycle after the starting request write and falls in the cycle after the last write state.
- R9: The register offsets are 0/1 source low/high, 2/3 destination low/high, 4/5 count, 6 page, 7 command, 8 mask and 9 request/status. Each reads back its current value, and writes to any of them are ignored while busy is high.
- R10: bus_rd and bus_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| bus_addr | output | PAGE_W+16 | Memory address {page, offset} |
| bus_dout | output | 8 | Write data from the holding register |
| bus_din | input | 8 | Read data from memory |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ready | input | 1 | Target ready; low inserts wait states |
| busy | output | 1 | Copy in progress |
| tc_out | output | 1 | One-cycle terminal-count pulse |

## Verification
The state register changes at the clock edge that samples a request write, so busy is due at the next falling-edge sample. With ready high, every byte takes eight cycles from that point, and busy falls together with the one-cycle tc_out pulse. Write data and strobe width are judged when bus_wr falls. The monitor counts the falling-edge samples during which the strobe was high, and pops the expected address and byte from the scoreboard queue at that moment. Register values and status are read back only after busy has dropped, and each read looks at the combinational read port one step after a falling edge.

// File: rtl/m2m_dma.sv
module m2m_dma #(
  parameter int PAGE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [3:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic [PAGE_W+15:0]   bus_addr,
  output logic [7:0]           bus_dout,
  input  logic [7:0]           bus_din,
  output logic                 bus_rd,
  output logic                 bus_wr,
  input  logic                 bus_ready,
  output logic                 busy,
  output logic                 tc_out
);
  localparam logic [3:0] A_REQ = 4'd9;

  typedef enum logic [3:0] {
    IDLE, RS1, RS2, RS3, RSW, RS4, WS1, WS2, WS3, WSW, WS4
  } st_t;

  st_t st, st_nx;
  logic [15:0] src_r, dst_r, cnt_r;
  logic [PAGE_W-1:0] page_r;
  logic [1:0] cmd_r, mask_r;
  logic [7:0] hold_r;
  logic req_r, tc_r;

  wire cfg_we = reg_we && st == IDLE;
  wire start  = cfg_we && reg_addr == A_REQ && reg_wdata[0] && cmd_r[1] && (&mask_r);
  wire wphase = st inside {WS1, WS2, WS3, WSW, WS4};

  assign busy     = st != IDLE;
  assign bus_rd   = st inside {RS2, RS3, RSW, RS4};
  assign bus_wr   = cmd_r[0] ? (st inside {WS3, WSW, WS4}) : (st == WS4);
  assign bus_addr = {page_r, wphase ? dst_r : src_r};
  assign bus_dout = hold_r;

  always_comb begin
    st_nx = st;
    case (st)
      IDLE:     if (start) st_nx = RS1;
      RS1:      st_nx = RS2;
      RS2:      st_nx = RS3;
      RS3, RSW: st_nx = bus_ready ? RS4 : RSW;
      RS4:      st_nx = WS1;
      WS1:      st_nx = WS2;
      WS2:      st_nx = WS3;
      WS3, WSW: st_nx = bus_ready ? WS4 : WSW;
      WS4:      st_nx = (cnt_r == 16'd0) ? IDLE : RS1;
      default:  st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      src_r  <= '0;
      dst_r  <= '0;
      cnt_r  <= '0;
      page_r <= '0;
      cmd_r  <= '0;
      mask_r <= '0;
      hold_r <= '0;
      req_r  <= 1'b0;
      tc_r   <= 1'b0;
      tc_out <= 1'b0;
    end else begin
      st     <= st_nx;
      tc_out <= 1'b0;
      if (st == RS4) hold_r <= bus_din;
      if (cfg_we) begin
        case (reg_addr)
          4'd0: src_r[7:0]  <= reg_wdata;
          4'd1: src_r[15:8] <= reg_wdata;
          4'd2: dst_r[7:0]  <= reg_wdata;
          4'd3: dst_r[15:8] <= reg_wdata;
          4'd4: cnt_r[7:0]  <= reg_wdata;
          4'd5: cnt_r[15:8] <= reg_wdata;
          4'd6: page_r      <= reg_wdata[PAGE_W-1:0];
          4'd7: cmd_r       <= reg_wdata[1:0];
          4'd8: mask_r      <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (start) begin
        req_r <= 1'b1;
        tc_r  <= 1'b0;
      end
      if (st == WS4) begin
        src_r <= src_r + 16'd1;
        dst_r <= dst_r + 16'd1;
        cnt_r <= cnt_r - 16'd1;
        if (cnt_r == 16'd0) begin
          req_r  <= 1'b0;
          tc_r   <= 1'b1;
          tc_out <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = src_r[7:0];
      4'd1:    reg_rdata = src_r[15:8];
      4'd2:    reg_rdata = dst_r[7:0];
      4'd3:    reg_rdata = dst_r[15:8];
      4'd4:    reg_rdata = cnt_r[7:0];
      4'd5:    reg_rdata = cnt_r[15:8];
      4'd6:    reg_rdata = 8'(page_r);
      4'd7:    reg_rdata = {6'd0, cmd_r};
      4'd8:    reg_rdata = {6'd0, mask_r};
      4'd9:    reg_rdata = {5'd0, busy, tc_r, req_r};
      default: reg_rdata = 8'd0;
    endcase
  end

  // R10
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R5
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cmd_r[0]) |=> !bus_wr);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == A_REQ && reg_wdata[0]));

  // R7
  tc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (!busy && tc_r && !req_r));

  // R9
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(page_r) && $stable(cmd_r) && $stable(mask_r)));

  // R4
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == RS3 || st == RSW) && !bus_ready) |=> (st == RSW));
endmodule

// File: tb/m2m_dma_test.sv
module m2m_dma_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_we, bus_rd, bus_wr, bus_ready, busy, tc_out;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, bus_dout, bus_din;
  logic [23:0] bus_addr;

  int nchk = 0, nerr = 0;
  logic [31:0] exp_q[$];
  bit ext_mode = 0, stall_en = 0;
  int wr_w = 0, tc_cnt = 0;
  logic [23:0] last_addr;
  logic [7:0] last_data;

  m2m_dma #(.PAGE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ready(bus_ready), .busy(busy), .tc_out(tc_out));

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  assign bus_din = pat(bus_addr);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bus_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    if (rst_n) begin
      if (tc_out) tc_cnt++;
      if (bus_wr) begin
        wr_w++;
        last_addr = bus_addr;
        last_data = bus_dout;
      end else if (wr_w > 0) begin
        if (exp_q.size() == 0) begin
          check(0, "R3 extra write", {last_addr, last_data}, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check({last_addr, last_data} == e, "R3 write addr/data", {last_addr, last_data}, e);
        end
        if (ext_mode) check(wr_w >= 2, "R5 extended strobe width", wr_w, 2);
        else          check(wr_w == 1, "R5 normal strobe width", wr_w, 1);
        wr_w = 0;
      end
    end
  end

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd16(logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(a, lo);
    rd_reg(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic run_copy(logic [7:0] page, logic [15:0] src, logic [15:0] dst,
                          int len, bit ext, bit stall, bit poke);
    logic [15:0] cnt_m1, v;
    logic [7:0] s;
    int cyc;
    cnt_m1 = 16'(len - 1);
    stall_en = stall;
    ext_mode = ext;
    tc_cnt = 0;
    wr_reg(4'd6, page);
    wr_reg(4'd0, src[7:0]);  wr_reg(4'd1, src[15:8]);
    wr_reg(4'd2, dst[7:0]);  wr_reg(4'd3, dst[15:8]);
    wr_reg(4'd4, cnt_m1[7:0]); wr_reg(4'd5, cnt_m1[15:8]);
    wr_reg(4'd7, {6'd0, 1'b1, ext});
    wr_reg(4'd8, 8'h03);
    for (int i = 0; i < len; i++) begin
      logic [15:0] sa, da;
      sa = src + 16'(i);
      da = dst + 16'(i);
      exp_q.push_back({page, da, pat({page, sa})});
    end
    wr_reg(4'd9, 8'h01);
    check(busy == 1'b1, "R8 busy after request", busy, 1);
    cyc = 0;
    if (poke) begin
      wr_reg(4'd0, 8'hAA);
      wr_reg(4'd6, 8'h77);
      cyc = 2;
    end
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    if (!stall) check(cyc == 8 * len, "R4 cycles without waits", cyc, 8 * len);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 all bytes written", exp_q.size(), 0);
    check(tc_cnt == 1, "R7 single tc pulse", tc_cnt, 1);
    rd_reg(4'd9, s);
    check(s == 8'h02, "R7 status after copy", s, 8'h02);
    rd16(4'd4, v);
    check(v == 16'hFFFF, "R7 count after copy", v, 16'hFFFF);
    rd16(4'd0, v);
    check(v == src + 16'(len), "R6 source offset advanced", v, src + 16'(len));
    rd16(4'd2, v);
    check(v == dst + 16'(len), "R6 destination offset advanced", v, dst + 16'(len));
    rd_reg(4'd6, s);
    check(s == page, "R6 R9 page unchanged", s, page);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog busy=%b expected=0", busy);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 4'd0; reg_wdata = 8'd0; bus_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !tc_out && !bus_rd && !bus_wr, "R1 outputs after reset",
          {busy, tc_out, bus_rd, bus_wr}, 0);
    rd_reg(4'd9, s);
    check(s == 8'h00, "R1 status after reset", s, 0);

    // R2: copy mode set but mask clear
    wr_reg(4'd7, 8'h02);
    wr_reg(4'd8, 8'h00);
    wr_reg(4'd9, 8'h01);
    check(!busy, "R2 request ignored when unmasked", busy, 0);
    // R2: masked but copy mode clear
    wr_reg(4'd7, 8'h00);
    wr_reg(4'd8, 8'h03);
    wr_reg(4'd9, 8'h01);
    @(negedge clk);
    check(!busy, "R2 request ignored without copy mode", busy, 0);
    rd_reg(4'd9, s);
    check(s == 8'h00, "R2 status untouched", s, 0);

    run_copy(8'h12, 16'h0100, 16'h0800, 5, 0, 0, 0);
    run_copy(8'h12, 16'h2000, 16'h3000, 40, 0, 1, 0);
    // R9: writes during busy are dropped
    run_copy(8'h45, 16'h4000, 16'h6000, 40, 1, 1, 1);
    // R6: offset wrap inside page
    run_copy(8'h3C, 16'hFFFE, 16'hFFFD, 4, 1, 0, 0);
    run_copy(8'h01, 16'h0055, 16'h00AA, 1, 0, 0, 0);
    run_copy(8'h02, 16'h1234, 16'h8000, 24, 1, 1, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule